// File: doc/BRIEF.md
# I2C Multi-Master SDA Bit Engine

This block is the data-line half of an I2C master that shares its bus with other masters. A controller hands it one command at a time: START (which also serves as repeated START while the engine owns the bus), write a byte, read a byte and answer it with ACK or NACK, or STOP. A separate clock generator owns SCL and gives the engine two single-cycle strobes. One strobe falls in the middle of each SCL low phase and the other in the middle of each SCL high phase. The engine pulls SDA low through an open-drain enable and reads back the resolved SDA level.

Every bit the engine releases while it transmits is checked against the line at the high-phase strobe. If the line reads low while the engine left it released, another master has won. The engine then lets go of SDA at once and falls back to listening. It raises a sticky loss flag and does not put a STOP on the bus. A small line monitor tracks START and STOP conditions from any master and produces a bus-busy flag. A fresh START from the idle state waits on that flag.

Top module: `i2cm_bit_engine`

## Requirements
- R1: After reset `sda_oe`, `bus_busy`, `arb_lost` and `op_done` are 0 and `ready` is 1.
- R2: A write command (`cmd_op` = 2) shifts `cmd_data` out MSB first. Each bit's SDA level is set at the SCL-low strobe and held through the following SCL-high strobe, and the ninth bit is left released.
- R3: After a write, `ack_rcvd` is 1 when SDA was sampled low at the ninth SCL-high strobe and 0 when it was sampled high.
- R4: A read command (`cmd_op` = 3) builds `rx_byte` MSB first from SDA samples taken at eight SCL-high strobes. On the ninth bit it pulls SDA low when `cmd_ack` = 1 (ACK) and releases it when `cmd_ack` = 0 (NACK).
- R5: A START command (`cmd_op` = 1) releases SDA at an SCL-low strobe and pulls it low at the next SCL-high strobe. Issued while the engine owns the bus, it forms a repeated START with no STOP in between.
- R6: A STOP command (`cmd_op` = 4) pulls SDA low at an SCL-low strobe and releases it at the next SCL-high strobe, giving a rising SDA edge while SCL is high. The engine then leaves master mode.
- R7: When SDA is sampled low at an SCL-high strobe on a bit the engine is sending as released (a write data bit or a NACK), `sda_oe` is 0 from the next cycle and `arb_lost` becomes 1. That command reports no `op_done`, and the engine drives nothing until a new START is accepted.
- R8: An arbitration loss produces no STOP condition on the bus.
- R9: `arb_lost` stays 1 until a cycle with `arb_clr` = 1 clears it.
- R10: `bus_busy` goes to 1 after any falling SDA edge while SCL is high and to 0 after any rising SDA edge while SCL is high, whichever master caused it.
- R11: A START command given while the engine is idle and `bus_busy` is 1 is dropped: SDA is not driven and no `op_done` follows.
- R12: `op_done` is a one-cycle pulse at the end of each completed command. `ready` is 0 while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `ready` is 1 |
| cmd_op | input | 3 | 1 START, 2 write, 3 read, 4 STOP, others ignored |
| cmd_data | input | 8 | Byte to write |
| cmd_ack | input | 1 | For reads: 1 answers ACK, 0 answers NACK |
| arb_clr | input | 1 | Clears the arbitration-lost flag |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| ph_low | input | 1 | Strobe in the middle of SCL low |
| ph_high | input | 1 | Strobe in the middle of SCL high |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ready | output | 1 | Engine can take a command |
| op_done | output | 1 | Command-complete pulse |
| rx_byte | output | 8 | Last byte read |
| ack_rcvd | output | 1 | 1 when the last write was acknowledged |
| bus_busy | output | 1 | Bus held by some master |
| arb_lost | output | 1 | Sticky arbitration-lost flag |

## Verification
Writes are swept over all 256 byte values, with the slave acknowledging or not depending on the low bit of the byte. This separates bit order and per-bit drive errors from ACK-sampling errors. Reads are swept over all 256 values, alternating ACK and NACK, which checks the shift-in order and the polarity of the ninth bit independently of each other. Arbitration loss is forced at each of the eight bit positions of an all-ones byte. That run shows whether the engine compares every bit, keeps the bus free of a STOP, holds the sticky flag, and rejects a START while another master holds the bus. A START–write–repeated START–read–STOP sequence tells a repeated START apart from a STOP followed by a START.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_START = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_STOP  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_START,
    S_STOP,
    S_XFER
  } st_e;
endpackage

// File: rtl/i2cm_rst_sync.sv
module i2cm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_busy
);
  logic scl_q, sda_q, busy_q, busy_d;
  logic start_seen, stop_seen;

  assign start_seen = scl_i && scl_q && sda_q && !sda_i;
  assign stop_seen  = scl_i && scl_q && !sda_q && sda_i;

  always_comb begin
    busy_d = busy_q;
    if (start_seen)     busy_d = 1'b1;
    else if (stop_seen) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      busy_q <= busy_d;
    end
  end

  assign bus_busy = busy_q;
endmodule

// File: rtl/i2cm_arb_flag.sv
module i2cm_arb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  op_e               cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ack,
  input  logic              ph_low,
  input  logic              ph_high,
  input  logic              sda_i,
  input  logic              bus_busy,
  output logic              sda_oe,
  output logic              ready,
  output logic              op_done,
  output logic              lose_pulse,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_rcvd
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  st_e               st_q, st_d;
  logic [1:0]        sub_q, sub_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] rxo_q, rxo_d;
  logic              acks_q, acks_d;
  logic              rd_q, rd_d;
  logic              ackc_q, ackc_d;
  logic              oe_q, oe_d;
  logic              done_q, done_d;
  logic              lose_q, lose_d;
  logic              last_bit;
  logic              clash;

  assign last_bit = (cnt_q == LAST_BIT);
  // released by us, pulled low by someone else
  assign clash    = !oe_q && !sda_i;

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    cnt_d  = cnt_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    rxo_d  = rxo_q;
    acks_d = acks_q;
    rd_d   = rd_q;
    ackc_d = ackc_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    lose_d = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        oe_d = 1'b0;
        if (cmd_valid && cmd_op == OP_START && !bus_busy) begin
          st_d  = S_START;
          sub_d = 2'd0;
        end
      end
      S_HOLD: begin
        if (cmd_valid) begin
          case (cmd_op)
            OP_START: begin
              st_d  = S_START;
              sub_d = 2'd0;
            end
            OP_WRITE: begin
              st_d  = S_XFER;
              sub_d = 2'd0;
              cnt_d = '0;
              rd_d  = 1'b0;
              tx_d  = cmd_data;
            end
            OP_READ: begin
              st_d   = S_XFER;
              sub_d  = 2'd0;
              cnt_d  = '0;
              rd_d   = 1'b1;
              ackc_d = cmd_ack;
            end
            OP_STOP: begin
              st_d  = S_STOP;
              sub_d = 2'd0;
            end
            default: ;
          endcase
        end
      end
      S_START: begin
        case (sub_q)
          2'd0: if (ph_low) begin
            oe_d  = 1'b0;
            sub_d = 2'd1;
          end
          2'd1: if (ph_high) begin
            oe_d  = 1'b1;
            sub_d = 2'd2;
          end
          default: if (ph_low) begin
            done_d = 1'b1;
            st_d   = S_HOLD;
          end
        endcase
      end
      S_STOP: begin
        if (sub_q == 2'd0) begin
          if (ph_low) begin
            oe_d  = 1'b1;
            sub_d = 2'd1;
          end
        end else if (ph_high) begin
          oe_d   = 1'b0;
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      S_XFER: begin
        if (sub_q == 2'd0) begin
          if (ph_low) begin
            if (last_bit) oe_d = rd_q ? ackc_q : 1'b0;
            else          oe_d = rd_q ? 1'b0 : !tx_q[DATA_W-1];
            sub_d = 2'd1;
          end
        end else if (ph_high) begin
          sub_d = 2'd0;
          if (!last_bit) begin
            cnt_d = cnt_q + 1'b1;
            if (rd_q) begin
              rx_d = {rx_q[DATA_W-2:0], sda_i};
            end else if (clash) begin
              oe_d   = 1'b0;
              lose_d = 1'b1;
              st_d   = S_IDLE;
            end else begin
              tx_d = {tx_q[DATA_W-2:0], 1'b0};
            end
          end else if (rd_q) begin
            if (clash) begin
              oe_d   = 1'b0;
              lose_d = 1'b1;
              st_d   = S_IDLE;
            end else begin
              rxo_d  = rx_q;
              done_d = 1'b1;
              st_d   = S_HOLD;
            end
          end else begin
            acks_d = !sda_i;
            done_d = 1'b1;
            st_d   = S_HOLD;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sub_q  <= 2'd0;
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxo_q  <= '0;
      acks_q <= 1'b0;
      rd_q   <= 1'b0;
      ackc_q <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      lose_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rxo_q  <= rxo_d;
      acks_q <= acks_d;
      rd_q   <= rd_d;
      ackc_q <= ackc_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      lose_q <= lose_d;
    end
  end

  assign sda_oe     = oe_q;
  assign ready      = (st_q == S_IDLE) || (st_q == S_HOLD);
  assign op_done    = done_q;
  assign lose_pulse = lose_q;
  assign rx_byte    = rxo_q;
  assign ack_rcvd   = acks_q;
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ack,
  input  logic              arb_clr,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ph_low,
  input  logic              ph_high,
  output logic              sda_oe,
  output logic              ready,
  output logic              op_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_rcvd,
  output logic              bus_busy,
  output logic              arb_lost
);
  logic rst_n_int;
  logic lose_pulse;
  op_e  op_dec;

  assign op_dec = op_e'(cmd_op);

  i2cm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  i2cm_bus_mon u_mon (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .bus_busy (bus_busy)
  );

  i2cm_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cmd_valid  (cmd_valid),
    .cmd_op     (op_dec),
    .cmd_data   (cmd_data),
    .cmd_ack    (cmd_ack),
    .ph_low     (ph_low),
    .ph_high    (ph_high),
    .sda_i      (sda_i),
    .bus_busy   (bus_busy),
    .sda_oe     (sda_oe),
    .ready      (ready),
    .op_done    (op_done),
    .lose_pulse (lose_pulse),
    .rx_byte    (rx_byte),
    .ack_rcvd   (ack_rcvd)
  );

  i2cm_arb_flag u_arb (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set_i  (lose_pulse),
    .clr_i  (arb_clr),
    .flag_o (arb_lost)
  );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk,
  input logic rst_n,
  input logic arb_clr,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe,
  input logic ready,
  input logic op_done,
  input logic bus_busy,
  input logic arb_lost
);
  // R7: by the time the loss flag rises, SDA is already released
  p_release_on_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !sda_oe);

  // R7: a lost command does not signal completion
  p_no_done_on_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !op_done);

  // R9: the loss flag holds until cleared
  p_sticky_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !arb_clr) |=> arb_lost);

  // R10: a rising SDA edge during SCL high frees the bus
  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !bus_busy);

  // R10: a falling SDA edge during SCL high marks the bus busy
  p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> bus_busy);

  // R12: completion is a single-cycle pulse seen with the engine ready
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  p_done_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> ready);
endmodule

bind i2cm_bit_engine i2cm_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arb_clr  (arb_clr),
  .scl_i    (scl_i),
  .sda_i    (sda_i),
  .sda_oe   (sda_oe),
  .ready    (ready),
  .op_done  (op_done),
  .bus_busy (bus_busy),
  .arb_lost (arb_lost)
);

// File: tb/sim_i2cm_bit_engine.sv
`timescale 1ns/1ps
module sim_i2cm_bit_engine;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic       cmd_ack;
  logic       arb_clr;
  logic       scl_i, sda_i, ph_low, ph_high;
  logic       sda_oe, ready, op_done, ack_rcvd, bus_busy, arb_lost;
  logic [7:0] rx_byte;
  logic       slv_oe, oth_oe;

  int compared, mismatched, cyc;
  int done_cnt, start_cnt, stop_cnt, oe_cnt;
  logic prev_scl, prev_sda;

  assign sda_i = !(sda_oe | slv_oe | oth_oe);

  i2cm_bit_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .arb_clr(arb_clr),
    .scl_i(scl_i), .sda_i(sda_i), .ph_low(ph_low), .ph_high(ph_high),
    .sda_oe(sda_oe), .ready(ready), .op_done(op_done), .rx_byte(rx_byte),
    .ack_rcvd(ack_rcvd), .bus_busy(bus_busy), .arb_lost(arb_lost)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // SCL generator: 8 clocks per bit, strobes mid-low and mid-high
  initial begin
    scl_i = 1'b1; ph_low = 1'b0; ph_high = 1'b0;
    forever begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        scl_i   = (c >= 4);
        ph_low  = (c == 2);
        ph_high = (c == 6);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // line monitor, sampled clear of both clock edges
  initial begin
    done_cnt = 0; start_cnt = 0; stop_cnt = 0; oe_cnt = 0; cyc = 0;
    prev_scl = 1'b1; prev_sda = 1'b1;
    forever begin
      @(posedge clk);
      #3;
      cyc++;
      if (op_done) done_cnt++;
      if (sda_oe) oe_cnt++;
      if (prev_scl && scl_i && prev_sda && !sda_i) start_cnt++;
      if (prev_scl && scl_i && !prev_sda && sda_i) stop_cnt++;
      prev_scl = scl_i;
      prev_sda = sda_i;
      if (cyc == 150000) begin
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual cycles %0d expected fewer", cyc);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_ph(input bit hi);
    do @(posedge clk); while (!(hi ? ph_high : ph_low));
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic a);
    @(negedge clk);
    while (!ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_ack = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(posedge clk);
    #4;
  endtask

  task automatic do_start();
    int d0, s0, p0;
    d0 = done_cnt; s0 = start_cnt; p0 = stop_cnt;
    issue(3'd1, 8'h00, 1'b0);
    wait_done(d0);
    chk("R5 start condition seen", start_cnt, s0 + 1);
    chk("R5 no stop before start", stop_cnt, p0);
    chk("R10 busy after start", bus_busy, 1);
    chk("R12 one done for start", done_cnt, d0 + 1);
  endtask

  task automatic do_stop();
    int d0, p0;
    d0 = done_cnt; p0 = stop_cnt;
    issue(3'd4, 8'h00, 1'b0);
    wait_done(d0);
    chk("R6 stop condition seen", stop_cnt, p0 + 1);
    chk("R6 sda released after stop", sda_oe, 0);
    repeat (2) @(posedge clk);
    #3;
    chk("R10 busy cleared after stop", bus_busy, 0);
  endtask

  task automatic do_write(input logic [7:0] b, input logic sack, input bit probe);
    int d0;
    logic [8:0] obs;
    d0 = done_cnt; obs = '0;
    issue(3'd2, b, 1'b0);
    for (int i = 0; i < 9; i++) begin
      wait_ph(0);
      #1 slv_oe = (i == 8) && sack;
      wait_ph(1);
      #1 obs = {obs[7:0], sda_i};
      if (probe && i == 3) chk("R12 ready low mid-transfer", ready, 0);
    end
    wait_ph(0);
    #1 slv_oe = 1'b0;
    chk("R2 byte on bus msb first", obs[8:1], b);
    chk("R2 ninth bit left to slave", obs[0], !sack);
    chk("R3 ack status", ack_rcvd, sack);
    chk("R12 one done for write", done_cnt, d0 + 1);
  endtask

  task automatic do_read(input logic [7:0] b, input logic mack);
    int d0;
    logic ackbit;
    d0 = done_cnt;
    issue(3'd3, 8'h00, mack);
    for (int i = 0; i < 8; i++) begin
      wait_ph(0);
      #1 slv_oe = !b[7-i];
      wait_ph(1);
    end
    wait_ph(0);
    #1 slv_oe = 1'b0;
    wait_ph(1);
    #1 ackbit = sda_i;
    wait_ph(0);
    #2;
    chk("R4 received byte", rx_byte, b);
    chk("R4 ninth bit polarity", ackbit, !mack);
    chk("R12 one done for read", done_cnt, d0 + 1);
  endtask

  task automatic arb_case(input int k);
    int d0, p0;
    do_start();
    d0 = done_cnt; p0 = stop_cnt;
    issue(3'd2, 8'hFF, 1'b0);
    for (int i = 0; i <= k; i++) begin
      wait_ph(0);
      if (i == k) #1 oth_oe = 1'b1;
      wait_ph(1);
    end
    repeat (3) @(posedge clk);
    #3;
    chk("R7 loss flag raised", arb_lost, 1);
    chk("R7 sda released after loss", sda_oe, 0);
    chk("R7 no done on loss", done_cnt, d0);
    chk("R8 no stop on loss", stop_cnt, p0);
    chk("R10 bus still busy", bus_busy, 1);
    oe_cnt = 0; d0 = done_cnt;
    issue(3'd1, 8'h00, 1'b0);
    repeat (24) @(posedge clk);
    #3;
    chk("R11 start ignored while busy, no drive", oe_cnt, 0);
    chk("R11 start ignored while busy, no done", done_cnt, d0);
    chk("R7 nothing driven after loss", sda_oe, 0);
    wait_ph(0);
    wait_ph(1);
    #1 oth_oe = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk("R10 other master stop frees bus", bus_busy, 0);
    chk("R8 only the other master stop seen", stop_cnt, p0 + 1);
    chk("R9 flag held across stop", arb_lost, 1);
    @(negedge clk); arb_clr = 1'b1;
    @(negedge clk); arb_clr = 1'b0;
    #4;
    chk("R9 flag cleared", arb_lost, 0);
  endtask

  initial begin
    compared = 0; mismatched = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'h00;
    cmd_ack = 1'b0; arb_clr = 1'b0; slv_oe = 1'b0; oth_oe = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sda released", sda_oe, 0);
    chk("R1 bus idle", bus_busy, 0);
    chk("R1 no loss", arb_lost, 0);
    chk("R1 ready", ready, 1);
    chk("R1 no done", op_done, 0);

    // write sweep: every byte, slave acks even bytes
    do_start();
    for (int b = 0; b < 256; b++) do_write(8'(b), !b[0], b == 0);
    do_stop();

    // read sweep: every byte, ACK and NACK alternating
    do_start();
    for (int b = 0; b < 256; b++) do_read(8'(b), b[0]);
    do_stop();

    // repeated START between write and read
    do_start();
    do_write(8'hA5, 1'b1, 1'b0);
    begin
      int p0;
      p0 = stop_cnt;
      do_start();
      chk("R5 repeated start keeps bus", bus_busy, 1);
      chk("R5 repeated start without stop", stop_cnt, p0);
    end
    do_read(8'h3C, 1'b0);
    do_stop();

    // arbitration loss at every bit position
    for (int k = 0; k < 8; k++) arb_case(k);

    summary();
    $finish;
  end
endmodule